// File: doc/BRIEF.md
# Write-Once Array Store with Deferred Reads

This block holds the arrays of a dataflow program in a word store where each element is written exactly once. Three kinds of request arrive on one request port. An allocate request reserves a run of consecutive words and returns the first address. A write request fills one word. A read request fetches one word. A read that reaches a word before its value exists is not refused and does not return a stale value. It is parked. When the write for that word arrives, every parked reader gets the written value, and each response carries the return tag that the reader supplied.

Each word keeps three status bits: in use (inside an allocated region), filled (written), and pending (at least one reader parked). Parked reads are held as one linked list per word, built from a shared pool of entries. A write to a word with readers parked sends them out one response per cycle in the order they arrived. While it does so, the request port is closed. Each request is answered in the cycle after it is accepted, except a read that is parked, which is answered only when its word is written.

Top module: `pbit_array_store`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, and the allocation pointer is 0.
- R2: An allocate request (`req_op`=0, length in `req_data`) that fits answers with kind BASE (`rsp_kind`=1) and the first address of the region in `rsp_data`. It advances the pointer by the length, so consecutive regions are contiguous. A region that ends exactly at the last word fits.
- R3: An allocate request with length 0, or one that would run past the last word, answers with kind ERR (`rsp_kind`=3) and `rsp_data`=0, and leaves the pointer unchanged.
- R4: A write (`req_op`=1) or read (`req_op`=2) to a word outside every allocated region answers with ERR and changes nothing.
- R5: A write to an allocated word that has not been written stores `req_data`, sets the filled bit, and answers with kind ACK (`rsp_kind`=2) and `rsp_data`=0.
- R6: A read of a filled word answers on the next cycle with kind DATA (`rsp_kind`=0) and the stored value. It is never parked.
- R7: A read of an allocated word that has not been written produces no response when it is accepted.
- R8: A write to a word with parked readers answers with ACK. In each of the following cycles it then emits one DATA response with the written value, one per parked reader, in arrival order. `req_ready` stays low from the ACK cycle until the last of these responses.
- R9: A write to a word that is already filled answers with ERR and leaves the stored value unchanged.
- R10: While all pool entries are in use, a read of an unfilled allocated word is held off with `req_ready` low. Other requests are still accepted. Once the entries are released, such reads are accepted again.
- R11: Every response echoes, in `rsp_tag`, the tag of the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_op | input | 2 | 0 allocate, 1 write, 2 read, 3 reserved (answers ERR) |
| req_addr | input | ADDR_W | Word address for write and read |
| req_data | input | DATA_W | Write value, or region length for allocate |
| req_tag | input | TAG_W | Return tag |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 DATA, 1 BASE, 2 ACK, 3 ERR |
| rsp_data | output | DATA_W | Read value or region base |
| rsp_tag | output | TAG_W | Tag of the answered request |

## Verification
A lost or mislinked pool entry shows up at the response port as a missing, duplicated or reordered DATA tag in the burst after the releasing write. This appears within the pool depth of cycles after that write. A filled or in-use bit that is wrong turns the next access to that word into the wrong response kind one cycle after it is accepted. A wrong allocation pointer appears in the base returned by the next allocate. A pool occupancy that is counted wrongly appears as `req_ready` dropping, or failing to drop, in the same cycle that a read of an unfilled word is offered.

// File: rtl/pbit_pkg.sv
package pbit_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RSP_DATA = 2'd0,
        RSP_BASE = 2'd1,
        RSP_ACK  = 2'd2,
        RSP_ERR  = 2'd3
    } rsp_e;

endpackage

// File: rtl/pbit_pool_pick.sv
// Picks the lowest free entry of the deferred-read pool and flags exhaustion.
module pbit_pool_pick #(
    parameter int POOL  = 8,
    parameter int PTR_W = 3
) (
    input  logic [POOL-1:0]  busy,
    output logic [PTR_W-1:0] free_idx,
    output logic             full
);
    always_comb begin
        free_idx = '0;
        for (int i = POOL - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_idx = PTR_W'(i);
            end
        end
        full = &busy;
    end
endmodule

// File: rtl/pbit_alloc_check.sv
// Decides whether a region of the requested length still fits behind the pointer.
module pbit_alloc_check #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int LEN_W = 16
) (
    input  logic [CNT_W-1:0] ptr,
    input  logic [LEN_W-1:0] len,
    output logic             fits,
    output logic [CNT_W-1:0] ptr_next
);
    logic [LEN_W:0] room;

    always_comb begin
        room     = (LEN_W+1)'(DEPTH) - (LEN_W+1)'(ptr);
        fits     = (len != '0) && ({1'b0, len} <= room);
        ptr_next = fits ? (ptr + CNT_W'(len)) : ptr;
    end
endmodule

// File: rtl/pbit_array_store.sv
module pbit_array_store
    import pbit_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 8,
    parameter int POOL   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;
    localparam int PTR_W = (POOL > 2) ? $clog2(POOL) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0]             used;
        logic [DEPTH-1:0]             filled;
        logic [DEPTH-1:0]             pending;
        logic [DEPTH-1:0][PTR_W-1:0]  head;
        logic [DEPTH-1:0][PTR_W-1:0]  tail;
        logic [POOL-1:0]              ent_busy;
        logic [POOL-1:0][TAG_W-1:0]   ent_tag;
        logic [POOL-1:0][PTR_W-1:0]   ent_next;
        logic [CNT_W-1:0]             alloc_ptr;
        logic                         rel_on;
        logic [PTR_W-1:0]             rel_ptr;
        logic [ADDR_W-1:0]            rel_word;
        logic [DATA_W-1:0]            rel_data;
        logic                         rsp_v;
        logic [1:0]                   rsp_k;
        logic [DATA_W-1:0]            rsp_d;
        logic [TAG_W-1:0]             rsp_t;
    } state_t;

    state_t st_d, st_q;

    logic [PTR_W-1:0] free_idx;
    logic             pool_full;
    logic             alloc_fits;
    logic [CNT_W-1:0] alloc_ptr_next;
    logic             accept;
    logic             park_blocked;

    // Exposed for the bound checker.
    logic [DEPTH-1:0] filled_vec;
    logic [DEPTH-1:0] used_vec;
    logic [CNT_W-1:0] alloc_ptr_now;

    pbit_pool_pick #(
        .POOL  (POOL),
        .PTR_W (PTR_W)
    ) u_pick (
        .busy     (st_q.ent_busy),
        .free_idx (free_idx),
        .full     (pool_full)
    );

    pbit_alloc_check #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .LEN_W (DATA_W)
    ) u_alloc (
        .ptr      (st_q.alloc_ptr),
        .len      (req_data),
        .fits     (alloc_fits),
        .ptr_next (alloc_ptr_next)
    );

    assign park_blocked = (op_e'(req_op) == OP_READ) && st_q.used[req_addr]
                          && !st_q.filled[req_addr] && pool_full;
    assign req_ready    = !st_q.rel_on && !park_blocked;
    assign accept       = req_valid && req_ready;

    assign filled_vec    = st_q.filled;
    assign used_vec      = st_q.used;
    assign alloc_ptr_now = st_q.alloc_ptr;

    assign rsp_valid = st_q.rsp_v;
    assign rsp_kind  = st_q.rsp_k;
    assign rsp_data  = st_q.rsp_d;
    assign rsp_tag   = st_q.rsp_t;

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;

        if (st_q.rel_on) begin
            // Drain one parked reader per cycle.
            st_d.rsp_v                  = 1'b1;
            st_d.rsp_k                  = RSP_DATA;
            st_d.rsp_d                  = st_q.rel_data;
            st_d.rsp_t                  = st_q.ent_tag[st_q.rel_ptr];
            st_d.ent_busy[st_q.rel_ptr] = 1'b0;
            if (st_q.rel_ptr == st_q.tail[st_q.rel_word]) begin
                st_d.rel_on                 = 1'b0;
                st_d.pending[st_q.rel_word] = 1'b0;
            end else begin
                st_d.rel_ptr = st_q.ent_next[st_q.rel_ptr];
            end
        end else if (accept) begin
            st_d.rsp_v = 1'b1;
            st_d.rsp_t = req_tag;
            st_d.rsp_d = '0;
            st_d.rsp_k = RSP_ERR;
            unique case (op_e'(req_op))
                OP_ALLOC: begin
                    if (alloc_fits) begin
                        st_d.rsp_k     = RSP_BASE;
                        st_d.rsp_d     = DATA_W'(st_q.alloc_ptr);
                        st_d.alloc_ptr = alloc_ptr_next;
                        for (int i = 0; i < DEPTH; i++) begin
                            if ((CNT_W'(i) >= st_q.alloc_ptr) && (CNT_W'(i) < alloc_ptr_next)) begin
                                st_d.used[i] = 1'b1;
                            end
                        end
                    end
                end
                OP_WRITE: begin
                    if (st_q.used[req_addr] && !st_q.filled[req_addr]) begin
                        st_d.mem[req_addr]    = req_data;
                        st_d.filled[req_addr] = 1'b1;
                        st_d.rsp_k            = RSP_ACK;
                        if (st_q.pending[req_addr]) begin
                            st_d.rel_on   = 1'b1;
                            st_d.rel_ptr  = st_q.head[req_addr];
                            st_d.rel_word = req_addr;
                            st_d.rel_data = req_data;
                        end
                    end
                end
                OP_READ: begin
                    if (st_q.used[req_addr] && st_q.filled[req_addr]) begin
                        st_d.rsp_k = RSP_DATA;
                        st_d.rsp_d = st_q.mem[req_addr];
                    end else if (st_q.used[req_addr]) begin
                        // Park: append to the word's list, no response now.
                        st_d.rsp_v              = 1'b0;
                        st_d.ent_busy[free_idx] = 1'b1;
                        st_d.ent_tag[free_idx]  = req_tag;
                        st_d.tail[req_addr]     = free_idx;
                        if (st_q.pending[req_addr]) begin
                            st_d.ent_next[st_q.tail[req_addr]] = free_idx;
                        end else begin
                            st_d.head[req_addr]    = free_idx;
                            st_d.pending[req_addr] = 1'b1;
                        end
                    end
                end
                OP_RSVD: begin
                    st_d.rsp_k = RSP_ERR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pbit_array_store_chk.sv
module pbit_array_store_chk #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [1:0]               req_op,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [TAG_W-1:0]         req_tag,
    input logic                     rsp_valid,
    input logic [1:0]               rsp_kind,
    input logic [TAG_W-1:0]         rsp_tag,
    input logic [(1<<ADDR_W)-1:0]   filled_vec,
    input logic [(1<<ADDR_W)-1:0]   used_vec,
    input logic [ADDR_W:0]          alloc_ptr_now
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_filled_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(filled_vec) & ~filled_vec) == '0));

    p_filled_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((filled_vec & ~used_vec) == '0));

    p_direct_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd2 && used_vec[req_addr] && filled_vec[req_addr])
        |=> (rsp_valid && rsp_kind == 2'd0 && rsp_tag == $past(req_tag)));

    p_park_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd2 && used_vec[req_addr] && !filled_vec[req_addr])
        |=> !rsp_valid);

    p_write_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd1 && filled_vec[req_addr])
        |=> (rsp_valid && rsp_kind == 2'd3));

    p_alloc_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd0)
        |=> (rsp_kind != 2'd3 || $stable(alloc_ptr_now)));

endmodule

bind pbit_array_store pbit_array_store_chk #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .req_tag       (req_tag),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .rsp_tag       (rsp_tag),
    .filled_vec    (filled_vec),
    .used_vec      (used_vec),
    .alloc_ptr_now (alloc_ptr_now)
);

// File: tb/tb_pbit_array_store.sv
module tb_pbit_array_store;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 8;
    localparam int POOL   = 8;

    localparam logic [1:0] K_DATA = 2'd0, K_BASE = 2'd1, K_ACK = 2'd2, K_ERR = 2'd3;
    localparam logic [1:0] O_AL = 2'd0, O_WR = 2'd1, O_RD = 2'd2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0]  rsp_tag;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic              g_v;
    logic [1:0]        g_k;
    logic [DATA_W-1:0] g_d;
    logic [TAG_W-1:0]  g_t;

    always #10 clk = ~clk;

    pbit_array_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .POOL   (POOL)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_tag   (req_tag),
        .rsp_valid (rsp_valid),
        .rsp_kind  (rsp_kind),
        .rsp_data  (rsp_data),
        .rsp_tag   (rsp_tag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One request; returns the response seen the cycle after acceptance.
    task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [TAG_W-1:0] t);
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_tag = t; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        g_v = rsp_valid; g_k = rsp_kind; g_d = rsp_data; g_t = rsp_tag;
    endtask

    task automatic next_rsp();
        @(negedge clk);
        #1;
        g_v = rsp_valid; g_k = rsp_kind; g_d = rsp_data; g_t = rsp_tag;
    endtask

    typedef struct packed {
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic [1:0]        ek;
        logic [DATA_W-1:0] ed;
        logic [3:0]        rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{O_AL, 6'd0,  16'd4,      8'd1,  K_BASE, 16'd0,  4'd2},  // R2 first base (R1 pointer 0)
        '{O_AL, 6'd0,  16'd8,      8'd2,  K_BASE, 16'd4,  4'd2},  // R2 contiguous
        '{O_WR, 6'd20, 16'h5555,   8'd3,  K_ERR,  16'd0,  4'd4},  // R4 write outside regions
        '{O_RD, 6'd20, 16'd0,      8'd4,  K_ERR,  16'd0,  4'd4},  // R4 read outside regions
        '{O_AL, 6'd0,  16'd0,      8'd5,  K_ERR,  16'd0,  4'd3},  // R3 zero length
        '{O_AL, 6'd0,  16'd60,     8'd6,  K_ERR,  16'd0,  4'd3},  // R3 past end
        '{O_AL, 6'd0,  16'd52,     8'd7,  K_BASE, 16'd12, 4'd2},  // R2 ends at last word; R3 pointer kept
        '{O_AL, 6'd0,  16'd1,      8'd8,  K_ERR,  16'd0,  4'd3},  // R3 store full
        '{O_WR, 6'd0,  16'h1111,   8'd9,  K_ACK,  16'd0,  4'd5},  // R5
        '{O_RD, 6'd0,  16'd0,      8'd10, K_DATA, 16'h1111, 4'd6},// R6
        '{O_WR, 6'd0,  16'h2222,   8'd11, K_ERR,  16'd0,  4'd9},  // R9 second write
        '{O_RD, 6'd0,  16'd0,      8'd12, K_DATA, 16'h1111, 4'd9} // R9 value kept
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "no response after reset", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].tag);
            chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d valid", i), 32'(g_v), 32'd1);
            chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d kind", i), 32'(g_k), 32'(VEC[i].ek));
            chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d data", i), 32'(g_d), 32'(VEC[i].ed));
            chk("R11", $sformatf("vec %0d tag", i), 32'(g_t), 32'(VEC[i].tag));
        end

        // R7: parked reads, two words interleaved
        send(O_RD, 6'd3, 16'd0, 8'd10); chk("R7", "park silent", 32'(g_v), 32'd0);
        send(O_RD, 6'd7, 16'd0, 8'd40); chk("R7", "park silent", 32'(g_v), 32'd0);
        send(O_RD, 6'd3, 16'd0, 8'd11); chk("R7", "park silent", 32'(g_v), 32'd0);
        send(O_RD, 6'd3, 16'd0, 8'd12); chk("R7", "park silent", 32'(g_v), 32'd0);

        // R8: release of word 3 only, in arrival order
        send(O_WR, 6'd3, 16'hABCD, 8'd20);
        chk("R8", "ack kind", 32'(g_k), 32'(K_ACK));
        chk("R8", "ready low at ack", 32'(req_ready), 32'd0);
        for (int j = 0; j < 3; j++) begin
            next_rsp();
            chk("R8", "release valid", 32'(g_v), 32'd1);
            chk("R8", "release kind", 32'(g_k), 32'(K_DATA));
            chk("R8", "release data", 32'(g_d), 32'hABCD);
            chk("R8", "release tag order", 32'(g_t), 32'(10 + j));
        end
        next_rsp();
        chk("R8", "burst ends", 32'(g_v), 32'd0);
        chk("R8", "ready back", 32'(req_ready), 32'd1);

        send(O_RD, 6'd3, 16'd0, 8'd21);
        chk("R6", "direct after release", 32'(g_d), 32'hABCD);
        chk("R11", "direct tag", 32'(g_t), 32'd21);

        send(O_WR, 6'd7, 16'h0777, 8'd22);
        chk("R8", "ack word 7", 32'(g_k), 32'(K_ACK));
        next_rsp();
        chk("R8", "word 7 reader tag", 32'(g_t), 32'd40);
        chk("R8", "word 7 reader data", 32'(g_d), 32'h0777);

        // R10: fill the pool
        for (int j = 0; j < POOL; j++) begin
            send(O_RD, 6'd5, 16'd0, 8'(50 + j));
            chk("R7", "pool fill silent", 32'(g_v), 32'd0);
        end
        @(negedge clk);
        req_op = O_RD; req_addr = 6'd6; req_valid = 1'b1;
        #1;
        chk("R10", "unfilled read held off", 32'(req_ready), 32'd0);
        req_addr = 6'd0;
        #1;
        chk("R10", "filled read still accepted", 32'(req_ready), 32'd1);
        req_valid = 1'b0;

        send(O_WR, 6'd5, 16'h5A5A, 8'd30);
        chk("R8", "ack word 5", 32'(g_k), 32'(K_ACK));
        for (int j = 0; j < POOL; j++) begin
            next_rsp();
            chk("R8", "full burst tag", 32'(g_t), 32'(50 + j));
            chk("R8", "full burst data", 32'(g_d), 32'h5A5A);
        end

        send(O_RD, 6'd6, 16'd0, 8'd60);
        chk("R10", "read accepted after drain", 32'(g_v), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule